// File: doc/BRIEF.md
# Interlace-Capable Vertical Timing Generator

This block produces the vertical half of a raster scan. A horizontal counter elsewhere supplies a pixel-clock enable, an end-of-line strobe and, for interlaced scanning, a mid-line strobe. From these the block keeps a line counter that wraps at a programmable total. It also drives vertical active, vertical blank and vertical sync, a one-cycle frame-start pulse and a field indicator.

Six 11-bit thresholds set the timing: total, active, blank start, blank end, sync start and sync end. Each is programmed as the target line minus one. The thresholds sit in pairs in three 32-bit registers. A control register holds a write-lock bit and the interlace enable. Software writes the stored copy at any time, and the counter adopts it only when a frame wraps.

In interlaced mode the counter advances on both the mid-line and the end-of-line strobe. With an odd number of counts per field, the sync pulse therefore starts mid-line in one field and at line end in the next.

Top module: `vtimer_top`

## Requirements
- R1: After reset the line count is 0, vBlank, vSync, frameStart and field are 0, and the register at address 1 reads total 524 / active 479.
- R2: A step occurs in a cycle with pixEn=1 and lineEnd=1 (or midLine=1 when interlace is live). A step raises the count by one. Without a step the count holds, and in progressive mode midLine alone does nothing.
- R3: A step taken while the count equals the live total sets the count to 0. frameStart is 1 for the single cycle that follows.
- R4: vActive is 1 exactly while the count is less than or equal to the live active threshold.
- R5: vBlank goes to 1 on the step that leaves count blankStart and to 0 on the step that leaves count blankEnd. For blankStart < blankEnd it is 1 for counts in (blankStart, blankEnd].
- R6: vSync follows the same rule with syncStart and syncEnd.
- R7: Register map, by regAddr:
  - 0: control, with bit 0 = lock and bit 1 = interlace.
  - 1: total in bits 26:16, active in bits 10:0.
  - 2: blank end in bits 26:16, blank start in bits 10:0.
  - 3: sync end in bits 26:16, sync start in bits 10:0.
  
  All other bits read 0, whatever was written.
- R8: While lock is 1, writes to addresses 1 to 3 leave the stored values unchanged. Address 0 is always writable.
- R9: Stored values, including the interlace bit, reach the counter only at a wrap. A frame in progress keeps its old timing.
- R10: With interlace live, midLine also steps the counter, and field inverts at every wrap. A wrap out of a progressive frame sets field to 0.
- R11: In interlaced mode with an odd number of counts per field (total even), vSync rises on a mid-line step in one field and on an end-of-line step in the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pixEn | input | 1 | Pixel-clock enable qualifying the strobes |
| lineEnd | input | 1 | End-of-line strobe from the horizontal counter |
| midLine | input | 1 | Mid-line strobe, used in interlaced mode |
| regWrEn | input | 1 | Register write enable |
| regAddr | input | 2 | Register address |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for regAddr |
| lineCount | output | 11 | Current vertical count |
| field | output | 1 | Field indicator |
| vActive | output | 1 | Vertical active region |
| vBlank | output | 1 | Vertical blank |
| vSync | output | 1 | Vertical sync |
| frameStart | output | 1 | One-cycle pulse after a wrap |

## Verification
A wrong count or a missed wrap shows on lineCount at the next step. It then spreads to vActive, vBlank and vSync for the rest of the frame. A wrongly latched set/reset flag stays wrong until the next matching threshold, which can be most of a frame later. For that reason the bench compares every output after every step over several whole frames of a small configuration.

A stale or early configuration load only shows at the frame boundary. The bench therefore checks the count against the old total just before the wrap and against the new one just after it. A wrong interlace phase shows as vSync rising on the same strobe type in two fields running.

// File: rtl/vtimer_pkg.sv
package vtimer_pkg;
  parameter int LINE_W = 11;
  parameter int HI_LSB = 16;
  parameter int DATA_W = 32;
  parameter int ADDR_W = 2;

  typedef logic [LINE_W-1:0] line_t;

  typedef struct packed {
    line_t total;
    line_t active;
    line_t blankStart;
    line_t blankEnd;
    line_t syncStart;
    line_t syncEnd;
    logic  interlace;
  } vtCfg_t;

  // control -> datapath
  typedef struct packed {
    logic step;
    logic wrap;
  } vtStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic atTotal;
    logic atBlankStart;
    logic atBlankEnd;
    logic atSyncStart;
    logic atSyncEnd;
  } vtMatch_t;
endpackage

// File: rtl/vtimer_regs.sv
module vtimer_regs
  import vtimer_pkg::*;
#(
  parameter vtCfg_t DEF_CFG = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output vtCfg_t            cfgStored
);
  localparam int LO_LSB = 0;

  logic lockBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgStored <= DEF_CFG;
      lockBit   <= 1'b0;
    end else if (regWrEn) begin
      case (regAddr)
        2'd0: begin
          lockBit             <= regWrData[0];
          cfgStored.interlace <= regWrData[1];
        end
        2'd1: if (!lockBit) begin
          cfgStored.total  <= regWrData[HI_LSB +: LINE_W];
          cfgStored.active <= regWrData[LO_LSB +: LINE_W];
        end
        2'd2: if (!lockBit) begin
          cfgStored.blankEnd   <= regWrData[HI_LSB +: LINE_W];
          cfgStored.blankStart <= regWrData[LO_LSB +: LINE_W];
        end
        default: if (!lockBit) begin
          cfgStored.syncEnd   <= regWrData[HI_LSB +: LINE_W];
          cfgStored.syncStart <= regWrData[LO_LSB +: LINE_W];
        end
      endcase
    end
  end

  always_comb begin
    regRdData = '0;
    case (regAddr)
      2'd0: begin
        regRdData[0] = lockBit;
        regRdData[1] = cfgStored.interlace;
      end
      2'd1: begin
        regRdData[HI_LSB +: LINE_W] = cfgStored.total;
        regRdData[LO_LSB +: LINE_W] = cfgStored.active;
      end
      2'd2: begin
        regRdData[HI_LSB +: LINE_W] = cfgStored.blankEnd;
        regRdData[LO_LSB +: LINE_W] = cfgStored.blankStart;
      end
      default: begin
        regRdData[HI_LSB +: LINE_W] = cfgStored.syncEnd;
        regRdData[LO_LSB +: LINE_W] = cfgStored.syncStart;
      end
    endcase
  end

  AST_LOCKED_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && lockBit && regAddr != '0) |=>
      ($stable(cfgStored.total) && $stable(cfgStored.active) &&
       $stable(cfgStored.blankStart) && $stable(cfgStored.blankEnd) &&
       $stable(cfgStored.syncStart) && $stable(cfgStored.syncEnd))); // R8
endmodule

// File: rtl/vtimer_datapath.sv
module vtimer_datapath
  import vtimer_pkg::*;
#(
  parameter vtCfg_t DEF_CFG = '0
) (
  input  logic      clk,
  input  logic      rstN,
  input  vtCfg_t    cfgStored,
  input  vtStrobe_t strb,
  output line_t     lineCount,
  output logic      ilLive,
  output logic      vActive,
  output vtMatch_t  match
);
  vtCfg_t cfgLive;
  line_t  lineCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineCnt <= '0;
      cfgLive <= DEF_CFG;
    end else if (strb.step) begin
      if (strb.wrap) begin
        lineCnt <= '0;
        cfgLive <= cfgStored;
      end else begin
        lineCnt <= lineCnt + line_t'(1);
      end
    end
  end

  always_comb begin
    match.atTotal      = (lineCnt == cfgLive.total);
    match.atBlankStart = (lineCnt == cfgLive.blankStart);
    match.atBlankEnd   = (lineCnt == cfgLive.blankEnd);
    match.atSyncStart  = (lineCnt == cfgLive.syncStart);
    match.atSyncEnd    = (lineCnt == cfgLive.syncEnd);
  end

  assign vActive   = (lineCnt <= cfgLive.active);
  assign lineCount = lineCnt;
  assign ilLive    = cfgLive.interlace;

  AST_HOLD_NO_STEP: assert property (@(posedge clk) disable iff (!rstN)
    !strb.step |=> $stable(lineCnt)); // R2
  AST_STEP_PLUS_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step && !strb.wrap) |=> (lineCnt == $past(lineCnt) + line_t'(1))); // R2
endmodule

// File: rtl/vtimer_control.sv
module vtimer_control
  import vtimer_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      pixEn,
  input  logic      lineEnd,
  input  logic      midLine,
  input  logic      ilLive,
  input  vtMatch_t  match,
  output vtStrobe_t strb,
  output logic      vBlank,
  output logic      vSync,
  output logic      field,
  output logic      frameStart
);
  always_comb begin
    strb.step = pixEn && (lineEnd || (ilLive && midLine));
    strb.wrap = strb.step && match.atTotal;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vBlank     <= 1'b0;
      vSync      <= 1'b0;
      field      <= 1'b0;
      frameStart <= 1'b0;
    end else begin
      frameStart <= strb.wrap;
      if (strb.wrap) field <= ilLive ? ~field : 1'b0;
      if (strb.step) begin
        if (match.atBlankEnd)        vBlank <= 1'b0;
        else if (match.atBlankStart) vBlank <= 1'b1;
        if (match.atSyncEnd)         vSync  <= 1'b0;
        else if (match.atSyncStart)  vSync  <= 1'b1;
      end
    end
  end

  AST_FIELD_ONLY_AT_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    !frameStart |-> $stable(field)); // R10
  AST_BLANK_ONLY_ON_STEP: assert property (@(posedge clk) disable iff (!rstN)
    !strb.step |=> ($stable(vBlank) && $stable(vSync))); // R5
endmodule

// File: rtl/vtimer_top.sv
module vtimer_top
  import vtimer_pkg::*;
#(
  parameter int DEF_TOTAL       = 524,
  parameter int DEF_ACTIVE      = 479,
  parameter int DEF_BLANK_START = 479,
  parameter int DEF_BLANK_END   = 524,
  parameter int DEF_SYNC_START  = 489,
  parameter int DEF_SYNC_END    = 491
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pixEn,
  input  logic              lineEnd,
  input  logic              midLine,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic [LINE_W-1:0] lineCount,
  output logic              field,
  output logic              vActive,
  output logic              vBlank,
  output logic              vSync,
  output logic              frameStart
);
  localparam vtCfg_t DEF_CFG = '{
    total:      line_t'(DEF_TOTAL),
    active:     line_t'(DEF_ACTIVE),
    blankStart: line_t'(DEF_BLANK_START),
    blankEnd:   line_t'(DEF_BLANK_END),
    syncStart:  line_t'(DEF_SYNC_START),
    syncEnd:    line_t'(DEF_SYNC_END),
    interlace:  1'b0
  };

  vtCfg_t    cfgStored;
  vtStrobe_t strb;
  vtMatch_t  match;
  logic      ilLive;

  vtimer_regs #(.DEF_CFG(DEF_CFG)) uRegs (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .cfgStored(cfgStored)
  );

  vtimer_datapath #(.DEF_CFG(DEF_CFG)) uPath (
    .clk(clk), .rstN(rstN), .cfgStored(cfgStored), .strb(strb),
    .lineCount(lineCount), .ilLive(ilLive), .vActive(vActive), .match(match)
  );

  vtimer_control uCtrl (
    .clk(clk), .rstN(rstN), .pixEn(pixEn), .lineEnd(lineEnd),
    .midLine(midLine), .ilLive(ilLive), .match(match), .strb(strb),
    .vBlank(vBlank), .vSync(vSync), .field(field), .frameStart(frameStart)
  );

  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |-> (lineCount == '0)); // R3
endmodule

// File: tb/vtimer_top_test.sv
`timescale 1ns/1ps
module vtimer_top_test;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rstN, pixEn, lineEnd, midLine, regWrEn;
  logic [1:0]  regAddr;
  logic [31:0] regWrData, regRdData;
  logic [10:0] lineCount;
  logic        field, vActive, vBlank, vSync, frameStart;

  vtimer_top uut (
    .clk(clk), .rstN(rstN), .pixEn(pixEn), .lineEnd(lineEnd), .midLine(midLine),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .lineCount(lineCount), .field(field),
    .vActive(vActive), .vBlank(vBlank), .vSync(vSync), .frameStart(frameStart)
  );

  int nRun = 0, nFail = 0;
  // live and pending model configuration
  int mCnt, mTot, mAct, mBs, mBe, mSs, mSe;
  int pTot, pAct, pBs, pBe, pSs, pSe;
  bit mIl, pIl, pLock, mField, mFs;

  task automatic check(bit ok, string req, string what, int act, int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit inRng(int c, int s, int e);
    return (c > s) && (c <= e);
  endfunction

  task automatic wrReg(int a, logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 2'(a); regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
    if (a == 0) begin pLock = d[0]; pIl = d[1]; end
    else if (!pLock) begin
      if (a == 1) begin pTot = d[26:16]; pAct = d[10:0]; end
      if (a == 2) begin pBe = d[26:16]; pBs = d[10:0]; end
      if (a == 3) begin pSe = d[26:16]; pSs = d[10:0]; end
    end
  endtask

  task automatic rdChk(int a, int exp, string req);
    @(negedge clk);
    regAddr = 2'(a);
    #1;
    check(regRdData == 32'(exp), req, "regRdData", int'(regRdData), exp);
  endtask

  task automatic checkAll();
    check(lineCount == 11'(mCnt), "R2", "lineCount", int'(lineCount), mCnt);
    check(vActive == (mCnt <= mAct), "R4", "vActive", int'(vActive), int'(mCnt <= mAct));
    check(vBlank == inRng(mCnt, mBs, mBe), "R5", "vBlank", int'(vBlank), int'(inRng(mCnt, mBs, mBe)));
    check(vSync == inRng(mCnt, mSs, mSe), "R6", "vSync", int'(vSync), int'(inRng(mCnt, mSs, mSe)));
    check(frameStart == mFs, "R3", "frameStart", int'(frameStart), int'(mFs));
    check(field == mField, "R10", "field", int'(field), int'(mField));
  endtask

  // one effective step; mid selects the mid-line strobe
  task automatic stepChk(bit mid);
    @(negedge clk);
    pixEn = 1'b1; lineEnd = !mid; midLine = mid;
    @(negedge clk);
    pixEn = 1'b0; lineEnd = 1'b0; midLine = 1'b0;
    if (mCnt == mTot) begin
      mCnt = 0; mFs = 1'b1;
      mField = mIl ? !mField : 1'b0;
      mIl = pIl; mTot = pTot; mAct = pAct; mBs = pBs; mBe = pBe; mSs = pSs; mSe = pSe;
    end else begin
      mCnt++; mFs = 1'b0;
    end
    checkAll();
  endtask

  bit doneRun = 0;
  initial begin
    #(4 * 200000);
    if (!doneRun) begin
      nRun++; nFail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    int seenRise;
    bit riseMid [2];
    rstN = 1'b0; pixEn = 1'b0; lineEnd = 1'b0; midLine = 1'b0;
    regWrEn = 1'b0; regAddr = '0; regWrData = '0;
    mCnt = 0; mTot = 524; mAct = 479; mBs = 479; mBe = 524; mSs = 489; mSe = 491;
    pTot = mTot; pAct = mAct; pBs = mBs; pBe = mBe; pSs = mSs; pSe = mSe;
    mIl = 0; pIl = 0; pLock = 0; mField = 0; mFs = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    check(lineCount == 0, "R1", "lineCount", int'(lineCount), 0);
    check(!vBlank && !vSync && !frameStart && !field, "R1", "flags",
          int'({vBlank, vSync, frameStart, field}), 0);
    rdChk(1, (524 << 16) | 479, "R1");
    rdChk(0, 0, "R7");

    // R7 layout, reserved bits read as zero
    wrReg(1, 32'hF800_F800 | (9 << 16) | 5);
    rdChk(1, (9 << 16) | 5, "R7");
    wrReg(2, (8 << 16) | 6);
    wrReg(3, (8 << 16) | 7);
    rdChk(3, (8 << 16) | 7, "R7");

    // R9: the running frame keeps the default total
    for (int i = 0; i < 524; i++) stepChk(1'b0);
    check(lineCount == 524, "R9", "count before wrap", int'(lineCount), 524);
    stepChk(1'b0);
    check(frameStart == 1'b1, "R9", "wrap at old total", int'(frameStart), 1);

    // progressive sweep over three frames of the new timing
    for (int i = 0; i < 30; i++) stepChk(1'b0);

    // R2: no step without pixEn; midLine ignored in progressive mode
    @(negedge clk); pixEn = 1'b0; lineEnd = 1'b1;
    @(negedge clk); lineEnd = 1'b0;
    check(lineCount == 11'(mCnt), "R2", "hold without pixEn", int'(lineCount), mCnt);
    @(negedge clk); pixEn = 1'b1; midLine = 1'b1;
    @(negedge clk); pixEn = 1'b0; midLine = 1'b0;
    check(lineCount == 11'(mCnt), "R2", "midLine in progressive", int'(lineCount), mCnt);

    // R8: locked registers ignore writes
    wrReg(0, 32'h1);
    rdChk(0, 1, "R7");
    wrReg(1, (20 << 16) | 3);
    rdChk(1, (9 << 16) | 5, "R8");
    for (int i = 0; i < 20; i++) stepChk(1'b0);
    wrReg(0, 32'h0);

    // interlaced setup: 11 counts per field
    wrReg(1, (10 << 16) | 5);
    wrReg(2, (10 << 16) | 6);
    wrReg(3, (9 << 16) | 7);
    wrReg(0, 32'h2);
    rdChk(0, 2, "R7");
    do stepChk(1'b0); while (!mFs);

    // R10/R11: alternate mid-line and end-of-line strobes
    seenRise = 0;
    for (int k = 0; k < 44; k++) begin
      bit prevSync;
      bit isMid;
      prevSync = vSync;
      isMid = (k % 2 == 0);
      stepChk(isMid);
      if (!prevSync && vSync && seenRise < 2) begin
        riseMid[seenRise] = isMid;
        seenRise++;
      end
    end
    check(seenRise == 2, "R11", "sync rises seen", seenRise, 2);
    check(riseMid[0] != riseMid[1], "R11", "sync rise strobe type differs",
          int'(riseMid[1]), int'(!riseMid[0]));

    doneRun = 1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule